// File: doc/BRIEF.md
# Latched BCD to Seven-Segment Decoder

This block turns a four-bit decimal digit into the seven active-high drive bits of a seven-segment display. A hold input chooses between following the incoming digit on every clock and freezing the digit captured when hold was first raised. Two active-low overrides act on the output stage. Lamp test lights every segment. Blanking darkens every segment. Lamp test takes priority over blanking, and blanking takes priority over the decoded digit.

The capture path is a small state machine with two states, `ST_TRACK` and `ST_HOLD`. The transition *capture* (from `ST_TRACK` to `ST_HOLD`) fires on the first clock edge at which hold is sampled high. That edge still loads the digit present on the input, so this edge is the capture point. The transition *release* (from `ST_HOLD` to `ST_TRACK`) fires on any edge at which hold is sampled low. The output stage chooses one of three modes, `OUT_LAMP`, `OUT_BLANK` or `OUT_SHOW`, and registers the resulting pattern.

Top module: `seg7_hold_decoder`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, the stored digit is cleared to 0, the state returns to `ST_TRACK`, and `seg_o` is driven to 7'h00 from the next edge.
- R2: Segment bit order is `seg_o[0]`=a, `[1]`=b, `[2]`=c, `[3]`=d, `[4]`=e, `[5]`=f, `[6]`=g. With both overrides inactive, the stored digits 0 to 9 give these patterns: 0→7'h3F, 1→7'h06, 2→7'h5B, 3→7'h4F, 4→7'h66, 5→7'h6D, 6→7'h7C (top segment off), 7→7'h07, 8→7'h7F, 9→7'h67 (no bottom tail).
- R3: A stored code from 10 to 15 gives `seg_o` = 7'h00 when both overrides are inactive.
- R4: On every edge at which `hold` is sampled low, the stored digit takes `digit_in`. The pattern for that digit appears on `seg_o` one edge later.
- R5: On the first edge at which `hold` is sampled high, the stored digit takes `digit_in`. On every later edge while `hold` stays high, the stored digit is frozen, and changes on `digit_in` have no effect on `seg_o`.
- R6: `lamp_n` sampled low makes `seg_o` equal 7'h7F after that edge, whatever the values of `blank_n`, `hold` and the digit.
- R7: `blank_n` sampled low while `lamp_n` is high makes `seg_o` equal 7'h00 after that edge, whatever the digit.
- R8: Lamp test and blanking never change the stored digit. When both are released, the held or tracked digit is displayed again on the next edge.
- R9: A change on `lamp_n` or `blank_n` shows on `seg_o` after one edge. A change on `digit_in` with hold low shows on `seg_o` after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digit_in | input | 4 | Decimal digit code |
| hold | input | 1 | High freezes the captured digit, low follows the input |
| lamp_n | input | 1 | Lamp test, active low, lights all segments |
| blank_n | input | 1 | Blanking, active low, darkens all segments |
| seg_o | output | 7 | Registered segment drive, bit 0 = a through bit 6 = g |

## Verification
The hardest situation to reach is the capture edge. On that edge hold rises while the digit changes at the same time, and the state machine must load that final digit and then ignore later ones. The stimulus drives a new digit and a high hold in the same cycle, then changes the digit during the hold. It also puts lamp test and blanking pulses in the middle of the hold, and applies a reset while hold is high. In each case the display must come back to the right frozen value.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
    localparam int DIGIT_W   = 4;
    localparam int SEG_W     = 7;
    localparam int MAX_DIGIT = 9;

    typedef enum logic {
        ST_TRACK = 1'b0,
        ST_HOLD  = 1'b1
    } hold_state_e;

    typedef enum logic [1:0] {
        OUT_LAMP  = 2'd0,
        OUT_BLANK = 2'd1,
        OUT_SHOW  = 2'd2
    } out_mode_e;
endpackage

// File: rtl/digit_hold_fsm.sv
module digit_hold_fsm
    import seg7_pkg::*;
#(
    parameter int DW = DIGIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [DW-1:0] digit_in,
    output logic [DW-1:0] stored
);
    hold_state_e state_q;
    hold_state_e state_d;
    logic        load_en;

    // capture: TRACK -> HOLD on first high hold; release: HOLD -> TRACK on low hold
    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        unique case (state_q)
            ST_TRACK: begin
                load_en = 1'b1;
                if (hold) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                load_en = !hold;
                if (!hold) state_d = ST_TRACK;
            end
            default: begin
                load_en = 1'b1;
                state_d = ST_TRACK;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_TRACK;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)          stored <= '0;
        else if (load_en) stored <= digit_in;
    end
endmodule

// File: rtl/seg_pattern_dec.sv
module seg_pattern_dec
    import seg7_pkg::*;
#(
    parameter int DW = DIGIT_W,
    parameter int SW = SEG_W
) (
    input  logic [DW-1:0] digit,
    output logic [SW-1:0] pattern
);
    // bit 0 = a ... bit 6 = g
    always_comb begin
        pattern = '0;
        if (digit <= DW'(MAX_DIGIT)) begin
            case (digit[3:0])
                4'd0:    pattern = SW'(7'h3F);
                4'd1:    pattern = SW'(7'h06);
                4'd2:    pattern = SW'(7'h5B);
                4'd3:    pattern = SW'(7'h4F);
                4'd4:    pattern = SW'(7'h66);
                4'd5:    pattern = SW'(7'h6D);
                4'd6:    pattern = SW'(7'h7C);
                4'd7:    pattern = SW'(7'h07);
                4'd8:    pattern = SW'(7'h7F);
                4'd9:    pattern = SW'(7'h67);
                default: pattern = '0;
            endcase
        end
    end
endmodule

// File: rtl/seg_drive_stage.sv
module seg_drive_stage
    import seg7_pkg::*;
#(
    parameter int SW = SEG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lamp_n,
    input  logic          blank_n,
    input  logic [SW-1:0] pattern,
    output logic [SW-1:0] seg_q
);
    out_mode_e mode;

    always_comb begin
        if (!lamp_n)       mode = OUT_LAMP;
        else if (!blank_n) mode = OUT_BLANK;
        else               mode = OUT_SHOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
        end else begin
            unique case (mode)
                OUT_LAMP:  seg_q <= '1;
                OUT_BLANK: seg_q <= '0;
                OUT_SHOW:  seg_q <= pattern;
                default:   seg_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/seg7_hold_decoder.sv
module seg7_hold_decoder
    import seg7_pkg::*;
#(
    parameter int DW = DIGIT_W,
    parameter int SW = SEG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] digit_in,
    input  logic          hold,
    input  logic          lamp_n,
    input  logic          blank_n,
    output logic [SW-1:0] seg_o
);
    logic [DW-1:0] stored_digit;
    logic [SW-1:0] dec_pattern;

    digit_hold_fsm #(.DW(DW)) hold_i (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .digit_in (digit_in),
        .stored   (stored_digit)
    );

    seg_pattern_dec #(.DW(DW), .SW(SW)) dec_i (
        .digit   (stored_digit),
        .pattern (dec_pattern)
    );

    seg_drive_stage #(.SW(SW)) drv_i (
        .clk     (clk),
        .rst     (rst),
        .lamp_n  (lamp_n),
        .blank_n (blank_n),
        .pattern (dec_pattern),
        .seg_q   (seg_o)
    );
endmodule

// File: rtl/seg7_hold_decoder_sva.sv
module seg7_hold_decoder_sva
    import seg7_pkg::*;
#(
    parameter int DW = DIGIT_W,
    parameter int SW = SEG_W
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] digit_in,
    input logic          hold,
    input logic          lamp_n,
    input logic          blank_n,
    input logic [SW-1:0] seg_o,
    input logic [DW-1:0] stored
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (seg_o == '0 && stored == '0));

    assert_idle_code_blank_R3: assert property (@(posedge clk) disable iff (rst)
        (lamp_n && blank_n && stored > DW'(MAX_DIGIT)) |=> seg_o == '0);

    assert_track_load_R4: assert property (@(posedge clk) disable iff (rst)
        !hold |=> stored == $past(digit_in));

    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && !$past(rst)) |=> $stable(stored));

    assert_lamp_all_on_R6: assert property (@(posedge clk) disable iff (rst)
        !lamp_n |=> seg_o == '1);

    assert_blank_all_off_R7: assert property (@(posedge clk) disable iff (rst)
        (lamp_n && !blank_n) |=> seg_o == '0);

    assert_override_keeps_digit_R8: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && !$past(rst) && (!lamp_n || !blank_n)) |=> $stable(stored));
endmodule

bind seg7_hold_decoder seg7_hold_decoder_sva #(.DW(DW), .SW(SW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .digit_in (digit_in),
    .hold     (hold),
    .lamp_n   (lamp_n),
    .blank_n  (blank_n),
    .seg_o    (seg_o),
    .stored   (stored_digit)
);

// File: tb/seg7_hold_decoder_tb_top.sv
module seg7_hold_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] digit_in;
    logic       hold;
    logic       lamp_n;
    logic       blank_n;
    logic [6:0] seg_o;

    int    checks   = 0;
    int    failures = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    logic [6:0] ref_tab [16];
    logic [3:0] m_stored;
    logic       m_prev_hold;
    logic [6:0] m_seg;

    always #10 clk = ~clk;

    seg7_hold_decoder dut_i (
        .clk      (clk),
        .rst      (rst),
        .digit_in (digit_in),
        .hold     (hold),
        .lamp_n   (lamp_n),
        .blank_n  (blank_n),
        .seg_o    (seg_o)
    );

    // behavioural reference: state in plain variables, updated per edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_stored    <= 4'd0;
            m_prev_hold <= 1'b0;
            m_seg       <= 7'h00;
        end else begin
            if (!hold || !m_prev_hold) m_stored <= digit_in;
            m_prev_hold <= hold;
            if (!lamp_n)       m_seg <= 7'h7F;
            else if (!blank_n) m_seg <= 7'h00;
            else               m_seg <= ref_tab[m_stored];
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cycles > 0) begin
            checks++;
            if (seg_o !== m_seg) begin
                failures++;
                $display("FAIL %s cycle %0d: seg_o=%h expected %h", cur_req, cycles, seg_o, m_seg);
            end
        end
    end

    task automatic expect_seg(input logic [6:0] exp, input string req);
        checks++;
        if (seg_o !== exp) begin
            failures++;
            $display("FAIL %s directed: seg_o=%h expected %h", req, seg_o, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        ref_tab[0] = 7'h3F; ref_tab[1] = 7'h06; ref_tab[2] = 7'h5B; ref_tab[3] = 7'h4F;
        ref_tab[4] = 7'h66; ref_tab[5] = 7'h6D; ref_tab[6] = 7'h7C; ref_tab[7] = 7'h07;
        ref_tab[8] = 7'h7F; ref_tab[9] = 7'h67;
        for (int k = 10; k < 16; k++) ref_tab[k] = 7'h00;

        rst = 1'b1; digit_in = 4'd7; hold = 1'b0; lamp_n = 1'b1; blank_n = 1'b1;
        step(3);
        cur_req = "R1";
        expect_seg(7'h00, "R1");
        rst = 1'b0;
        step(1);
        expect_seg(7'h3F, "R1");   // stored cleared to 0 shows digit 0

        // R2 / R3 / R4: track every code
        for (int d = 0; d < 16; d++) begin
            cur_req = (d < 10) ? "R2" : "R3";
            digit_in = 4'(d);
            step(2);
            expect_seg(ref_tab[d], cur_req);
        end
        cur_req = "R4";
        digit_in = 4'd6; step(1);
        digit_in = 4'd9; step(1);
        expect_seg(7'h7C, "R9");     // 6 visible two edges after being driven
        step(1);
        expect_seg(7'h67, "R4");

        // R6 / R7: every digit with every override combination
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 4; c++) begin
                cur_req = (c[1] == 1'b0) ? "R6" : (c[0] == 1'b0 ? "R7" : "R2");
                digit_in = 4'(d);
                lamp_n = c[1];
                blank_n = c[0];
                step(2);
            end
        end
        lamp_n = 1'b1; blank_n = 1'b1;
        digit_in = 4'd2; step(2);
        lamp_n = 1'b0; blank_n = 1'b0; step(1);
        expect_seg(7'h7F, "R6");
        lamp_n = 1'b1; step(1);
        expect_seg(7'h00, "R7");
        blank_n = 1'b1; step(1);
        expect_seg(7'h5B, "R9");

        // R5: capture on the edge where hold rises with a new digit
        cur_req = "R5";
        digit_in = 4'd3; step(2);
        digit_in = 4'd8; hold = 1'b1; step(1);
        for (int d = 0; d < 10; d++) begin
            digit_in = 4'((d * 7 + 1) % 16);
            step(1);
        end
        expect_seg(7'h7F, "R5");

        // R8: overrides during hold keep the frozen digit
        cur_req = "R8";
        lamp_n = 1'b0; digit_in = 4'd1; step(3);
        lamp_n = 1'b1; blank_n = 1'b0; digit_in = 4'd4; step(3);
        blank_n = 1'b1; step(1);
        expect_seg(7'h7F, "R8");

        // release back to tracking
        cur_req = "R4";
        hold = 1'b0; digit_in = 4'd5; step(2);
        expect_seg(7'h6D, "R4");

        // R1: reset while holding clears the frozen digit
        cur_req = "R1";
        digit_in = 4'd9; hold = 1'b1; step(2);
        rst = 1'b1; step(2);
        expect_seg(7'h00, "R1");
        rst = 1'b0; step(1);
        expect_seg(7'h3F, "R1");
        hold = 1'b0; step(3);
        expect_seg(7'h67, "R4");

        finish_run();
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end
endmodule